// File: doc/BRIEF.md
# Two-Channel Interleaved Result Averager

This block sits behind the decimation filter of an incremental ADC that is time-shared between two slowly varying quantities. Each filtered conversion result arrives as one signed word, with a one-bit tag that says which quantity it belongs to. Results for the two quantities usually alternate, but any order is accepted. The block keeps a separate running sum, result counter and skip counter for each tag. When a tag has collected M accepted results, the block emits their average with that tag and restarts the tag's sum from zero.

M is a power of two, set by a log2 configuration field. The average is the sum shifted arithmetically right by log2(M), so it rounds toward minus infinity. A second configuration field discards a number of leading results per channel after reset or clear, which covers the settling outputs of the filter ahead of the block. The clear input drops all partial sums and re-arms the skip for both channels.

Top module: `dual_chan_avg`

## Requirements
- R1: During and after reset, out_valid, out_chan and out_data are all zero until the first average is produced.
- R2: Results tagged 0 and 1 are summed and counted apart. A channel's average uses only results carrying that channel's tag, and it is tagged with that channel on out_chan.
- R3: An average appears with out_valid high for exactly one cycle, in the cycle after the clock edge that accepted the channel's M-th result. out_chan and out_data hold their values until the next average.
- R4: M equals 2 to the power cfg_log2m, and cfg_log2m values above 8 act as 8. out_data is the sum of the M results shifted arithmetically right by log2(M), which is the floor of the mean.
- R5: After a channel emits an average, its sum and count restart from zero. The next average of that channel covers exactly the next M accepted results of that channel.
- R6: After reset or clear, the first cfg_skip valid results of each channel are discarded. The skip is not applied again after an average; it applies again only after a further clear.
- R7: A clear cycle zeroes both sums and counts and re-arms both skips. A valid result presented in the same cycle as clear is discarded.
- R8: While in_valid is low, in_data and in_chan have no effect on any later output.
- R9: The sum cannot overflow. With M=256, 256 results of the most negative or most positive input value average to exactly that value.
- R10: cfg_log2m and cfg_skip are changed only together with a clear. With M=1 and no skip, every accepted result is passed straight to the output one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of both channels |
| in_valid | input | 1 | A result is present this cycle |
| in_chan | input | 1 | Channel tag of the result (0 or 1) |
| in_data | input | DATA_W (16) | Signed filter result |
| cfg_log2m | input | 4 | log2 of M, clamped to 8 |
| cfg_skip | input | SKIP_W (4) | Leading results to discard per channel |
| out_valid | output | 1 | One-cycle pulse with a new average |
| out_chan | output | 1 | Channel tag of the average |
| out_data | output | DATA_W (16) | Signed average, floor of the mean |

## Verification
Strictly alternating A/B results with different signs and magnitudes show whether the two sums stay apart and whether negative means round down rather than toward zero. Runs of one channel with idle gaps full of garbage data separate true accumulation from leakage of unqualified inputs. Clears issued mid-average, including one that coincides with a valid result, show that partial state is dropped and the skip re-arms only there. A long run with a pseudo-random channel order, M=8 and a skip of one, followed by full-scale inputs at M=256 and an oversized log2 setting, exercises sum width, clamping and arbitrary channel order against the reference model on every clock.

// File: rtl/dca_pkg.sv
package dca_pkg;

   // Number of interleaved quantities handled by the averager
   localparam int unsigned DCA_CHANNELS = 2;

   // Limit a configuration value to an upper bound
   function automatic int unsigned dca_min(input int unsigned a, input int unsigned b);
      return (a > b) ? b : a;
   endfunction

endpackage

// File: rtl/dca_chan.sv
module dca_chan #(
   parameter int DATA_W    = 16,
   parameter int LOG2M_MAX = 8,
   parameter int SKIP_W    = 4,
   localparam int ACC_W    = DATA_W + LOG2M_MAX,
   localparam int CNT_W    = LOG2M_MAX
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     hit,
   input  logic signed [DATA_W-1:0] din,
   input  logic [SKIP_W-1:0]        skip_cnt,
   input  logic [CNT_W-1:0]         last_idx,
   output logic                     term,
   output logic signed [ACC_W-1:0]  total
);

   logic signed [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [SKIP_W-1:0]       skipped_q;
   logic                    skipping;
   logic                    accept;
   logic signed [ACC_W-1:0] din_ext;

   // Sign extension of the incoming result to the sum width
   assign din_ext  = {{LOG2M_MAX{din[DATA_W-1]}}, din};
   assign skipping = (skipped_q < skip_cnt);
   assign accept   = hit && !clear && !skipping;
   assign total    = acc_q + din_ext;
   assign term     = accept && (cnt_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         skipped_q <= '0;
      end else if (clear) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         skipped_q <= '0;
      end else if (hit) begin
         if (skipping) begin
            skipped_q <= skipped_q + SKIP_W'(1);
         end else if (term) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else begin
            acc_q <= total;
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/dca_out.sv
module dca_out #(
   parameter int DATA_W    = 16,
   parameter int LOG2M_MAX = 8,
   parameter int N_CH      = 2,
   localparam int ACC_W    = DATA_W + LOG2M_MAX,
   localparam int SH_W     = $clog2(LOG2M_MAX + 1),
   localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_CH-1:0]          term,
   input  logic signed [ACC_W-1:0]  totals [N_CH],
   input  logic [SH_W-1:0]          shift,
   output logic                     out_valid,
   output logic [CH_W-1:0]          out_chan,
   output logic signed [DATA_W-1:0] out_data
);

   logic signed [ACC_W-1:0] sel;
   logic signed [ACC_W-1:0] shifted;
   logic [CH_W-1:0]         sel_chan;
   logic                    any;

   // At most one channel terminates per cycle: one input per cycle
   always_comb begin
      sel      = '0;
      sel_chan = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (term[i]) begin
            sel      = totals[i];
            sel_chan = CH_W'(i);
         end
      end
   end

   assign any     = |term;
   assign shifted = sel >>> shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= any;
         if (any) begin
            out_chan <= sel_chan;
            out_data <= shifted[DATA_W-1:0];
         end
      end
   end

endmodule

// File: rtl/dual_chan_avg.sv
module dual_chan_avg #(
   parameter int DATA_W    = 16,
   parameter int LOG2M_MAX = 8,
   parameter int SKIP_W    = 4,
   localparam int SH_W     = $clog2(LOG2M_MAX + 1),
   localparam int ACC_W    = DATA_W + LOG2M_MAX,
   localparam int CNT_W    = LOG2M_MAX
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     in_valid,
   input  logic                     in_chan,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic [SH_W-1:0]          cfg_log2m,
   input  logic [SKIP_W-1:0]        cfg_skip,
   output logic                     out_valid,
   output logic                     out_chan,
   output logic signed [DATA_W-1:0] out_data
);

   import dca_pkg::*;

   localparam int N_CH = DCA_CHANNELS;

   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_data_w
      $error("dual_chan_avg: DATA_W must be at least 2");
   end
   if (LOG2M_MAX < 1 || LOG2M_MAX > 16) begin : g_bad_log2m
      $error("dual_chan_avg: LOG2M_MAX must lie in 1..16");
   end
   if (SKIP_W < 1) begin : g_bad_skip_w
      $error("dual_chan_avg: SKIP_W must be at least 1");
   end
   if (N_CH != 2) begin : g_bad_nch
      $error("dual_chan_avg: the tag is one bit wide, two channels only");
   end

   logic [SH_W-1:0]         eff_sh;
   logic [CNT_W:0]          m_full;
   logic [CNT_W:0]          m_less;
   logic [CNT_W-1:0]        last_idx;
   logic [N_CH-1:0]         term_vec;
   logic signed [ACC_W-1:0] total_arr [N_CH];

   // Clamp the averaging length and derive the final count index
   assign eff_sh   = (cfg_log2m > SH_W'(LOG2M_MAX)) ? SH_W'(LOG2M_MAX) : cfg_log2m;
   assign m_full   = (CNT_W+1)'(1) << eff_sh;
   assign m_less   = m_full - (CNT_W+1)'(1);
   assign last_idx = m_less[CNT_W-1:0];

   for (genvar g = 0; g < N_CH; g++) begin : g_chan
      logic hit;
      assign hit = in_valid && (in_chan == 1'(g));

      dca_chan #(
         .DATA_W   (DATA_W),
         .LOG2M_MAX(LOG2M_MAX),
         .SKIP_W   (SKIP_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (clear),
         .hit     (hit),
         .din     (in_data),
         .skip_cnt(cfg_skip),
         .last_idx(last_idx),
         .term    (term_vec[g]),
         .total   (total_arr[g])
      );
   end

   dca_out #(
      .DATA_W   (DATA_W),
      .LOG2M_MAX(LOG2M_MAX),
      .N_CH     (N_CH)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .term     (term_vec),
      .totals   (total_arr),
      .shift    (eff_sh),
      .out_valid(out_valid),
      .out_chan (out_chan),
      .out_data (out_data)
   );

endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
   parameter int DATA_W    = 16,
   parameter int LOG2M_MAX = 8,
   parameter int SKIP_W    = 4,
   localparam int SH_W     = $clog2(LOG2M_MAX + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     clear,
   input logic                     in_valid,
   input logic                     in_chan,
   input logic signed [DATA_W-1:0] in_data,
   input logic [SH_W-1:0]          cfg_log2m,
   input logic [SKIP_W-1:0]        cfg_skip,
   input logic                     out_valid,
   input logic                     out_chan,
   input logic signed [DATA_W-1:0] out_data
);

   // R3: every average is caused by a result accepted one cycle earlier
   p_out_follows_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && !clear));

   // R2: the average carries the tag of the result that completed it
   p_out_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_chan == $past(in_chan)));

   // R7: a result arriving with clear is discarded
   p_clear_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !out_valid);

   // R8: an idle cycle never produces an average
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10: with M=1 and no skip every accepted result is passed on
   p_pass_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && cfg_log2m == '0 && cfg_skip == '0) |=> out_valid);

endmodule

bind dual_chan_avg dca_checker #(
   .DATA_W   (DATA_W),
   .LOG2M_MAX(LOG2M_MAX),
   .SKIP_W   (SKIP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear    (clear),
   .in_valid (in_valid),
   .in_chan  (in_chan),
   .in_data  (in_data),
   .cfg_log2m(cfg_log2m),
   .cfg_skip (cfg_skip),
   .out_valid(out_valid),
   .out_chan (out_chan),
   .out_data (out_data)
);

// File: tb/dual_chan_avg_test.sv
module dual_chan_avg_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               clear = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_chan = 1'b0;
   logic signed [15:0] in_data = '0;
   logic [3:0]         cfg_log2m = '0;
   logic [3:0]         cfg_skip = '0;
   logic               out_valid;
   logic               out_chan;
   logic signed [15:0] out_data;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Reference model state
   longint m_acc [2];
   int     m_cnt [2];
   int     m_skp [2];
   int     m_sh = 0;
   int     m_skip_cfg = 0;
   bit     exp_valid = 0;
   bit     exp_chan = 0;
   longint exp_data = 0;

   always #5 clk = ~clk;

   dual_chan_avg uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .in_valid (in_valid),
      .in_chan  (in_chan),
      .in_data  (in_data),
      .cfg_log2m(cfg_log2m),
      .cfg_skip (cfg_skip),
      .out_valid(out_valid),
      .out_chan (out_chan),
      .out_data (out_data)
   );

   task automatic compare(string tag);
      checks++;
      if (out_valid !== exp_valid || out_chan !== exp_chan ||
          longint'(out_data) != exp_data) begin
         failures++;
         $display("FAIL %s: actual valid=%0d chan=%0d data=%0d expected valid=%0d chan=%0d data=%0d",
                  tag, out_valid, out_chan, out_data, exp_valid, exp_chan, exp_data);
      end
   endtask

   // One clock: drive at the falling edge, update the model, check after the rising edge
   task automatic step(bit v, bit ch, int d, bit clr, string tag);
      longint sum;
      @(negedge clk);
      in_valid = v;
      in_chan  = ch;
      in_data  = d[15:0];
      clear    = clr;
      exp_valid = 0;
      if (clr) begin
         for (int i = 0; i < 2; i++) begin
            m_acc[i] = 0; m_cnt[i] = 0; m_skp[i] = 0;
         end
      end else if (v) begin
         if (m_skp[ch] < m_skip_cfg) begin
            m_skp[ch]++;
         end else begin
            sum = m_acc[ch] + longint'($signed(d[15:0]));
            m_cnt[ch]++;
            if (m_cnt[ch] >= (1 << m_sh)) begin
               exp_valid = 1;
               exp_chan  = ch;
               exp_data  = sum >>> m_sh;
               m_acc[ch] = 0;
               m_cnt[ch] = 0;
            end else begin
               m_acc[ch] = sum;
            end
         end
      end
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic configure(int l2, int skip);
      @(negedge clk);
      cfg_log2m  = 4'(l2);
      cfg_skip   = 4'(skip);
      m_sh       = (l2 > 8) ? 8 : l2;
      m_skip_cfg = skip;
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(0, i[0], 16'h5a5a + i, 0, tag);
   endtask

   initial begin
      logic [31:0] seed;
      for (int i = 0; i < 2; i++) begin
         m_acc[i] = 0; m_cnt[i] = 0; m_skp[i] = 0;
      end
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      compare("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      compare("R1 after reset");

      // R2 R4: alternating channels, M=4, negative mean rounds down
      configure(2, 0);
      step(0, 0, 0, 1, "R7 clear");
      step(1, 0, 10, 0, "R2");  step(1, 1, -5, 0, "R2");
      step(1, 0, 20, 0, "R2");  step(1, 1, -6, 0, "R2");
      step(1, 0, 30, 0, "R2");  step(1, 1, -7, 0, "R2");
      step(1, 0, 41, 0, "R4 A mean 25");
      step(1, 1, -9, 0, "R4 B mean -7");

      // R8: garbage while idle, then R5 restart of the next average
      idle(4, "R8");
      step(1, 0, 100, 0, "R5"); idle(2, "R8");
      step(1, 0, 100, 0, "R5"); step(1, 0, 101, 0, "R5");
      step(1, 0, 103, 0, "R5 A mean 101");
      step(1, 0, -1, 0, "R3 same channel back to back");
      idle(1, "R3 pulse ends");

      // R10: M=1 pass-through, consecutive outputs
      configure(0, 0);
      step(0, 0, 0, 1, "R10 clear");
      step(1, 0, 1234, 0, "R10"); step(1, 0, -4321, 0, "R10");
      step(1, 1, 77, 0, "R10");   idle(1, "R3 hold");

      // R6: skip three per channel, M=2, skip not reapplied after an average
      configure(1, 3);
      step(0, 0, 0, 1, "R6 clear");
      for (int i = 0; i < 3; i++) begin
         step(1, 0, 9999, 0, "R6 skipped A");
         step(1, 1, -9999, 0, "R6 skipped B");
      end
      step(1, 0, 4, 0, "R6"); step(1, 1, 8, 0, "R6");
      step(1, 0, 6, 0, "R6 A mean 5");
      step(1, 1, 11, 0, "R6 B mean 9");
      step(1, 0, 2, 0, "R6 no reskip"); step(1, 0, 3, 0, "R6 A mean 2");

      // R7: clear mid-average, with a result in the clear cycle
      step(1, 1, 500, 0, "R7 partial");
      step(1, 1, 600, 1, "R7 clear with input");
      for (int i = 0; i < 3; i++) step(1, 1, 1, 0, "R7 skip re-armed");
      step(1, 1, 20, 0, "R7"); step(1, 1, 30, 0, "R7 B mean 25");

      // R9: full-scale inputs at M=256
      configure(8, 0);
      step(0, 0, 0, 1, "R9 clear");
      for (int i = 0; i < 256; i++) begin
         step(1, 0, -32768, 0, "R9 min");
         step(1, 1, 32767, 0, "R9 max");
      end

      // R4: log2 setting above 8 acts as 8
      configure(12, 0);
      step(0, 0, 0, 1, "R4 clear");
      for (int i = 0; i < 256; i++) step(1, 1, i - 100, 0, "R4 clamp");
      idle(1, "R4");

      // R2 R5 R6: pseudo-random channel order, M=8, skip one
      configure(3, 1);
      step(0, 0, 0, 1, "R2 clear");
      seed = 32'h1ace_b00c;
      for (int i = 0; i < 3000; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         step(seed[30] | seed[29], seed[27], int'($signed(seed[23:8])), 0, "R2 random");
      end
      idle(2, "R8");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         failures++;
         $display("FAIL R3 watchdog: actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule